// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block forms the product of two 16-bit operands and folds it into a 40-bit accumulator value, one operation per clock. Each operand is widened to 17 bits before the multiply. A per-operand control picks whether the top bit is replicated (two's-complement) or a zero is prepended (unsigned), so a single 17x17 signed multiplier serves signed, unsigned and mixed products.

The product can be doubled for Q15 fractional arithmetic. A product saturation control pins the one fractional product that cannot be represented, (-1)x(-1), to the largest positive 32-bit value. The product is then added to or subtracted from the accumulator input. The sum can be rounded to the nearest multiple of 2^16 and clamped to the signed 32-bit range. The final value goes into an output register together with a zero flag and a valid strobe.

The caller supplies the operands, mode bits and accumulator value on every cycle that `in_valid` is high. The caller also owns the accumulator storage. It feeds `res` back as `acc_in` when it needs a running sum.

Top module: `frac_mac_unit`

## Requirements
- R1: Each 16-bit operand is widened to 17 bits: when its signed control is 1, bit 15 is copied into bit 16; when 0, bit 16 is 0.
- R2: With fractional mode off, the product is the 17x17 two's-complement product, sign-extended to 40 bits.
- R3: With fractional mode on, the product is the R2 product shifted left by one bit.
- R4: When product saturation, fractional mode and both widened operands equal to -32768 all hold, the product is 0x007FFFFFFF. In every other case the product saturation control has no effect.
- R5: `sub_mode`=0 gives `acc_in` plus product; `sub_mode`=1 gives `acc_in` minus product, both modulo 2^40.
- R6: With `round_en`=1, 0x8000 is added to the R5 value (modulo 2^40) and then bits 15..0 are cleared.
- R7: With `sat_acc`=1, the value after R6 is treated as signed 40-bit. Above 0x007FFFFFFF it becomes 0x007FFFFFFF; below 0xFF80000000 (as signed) it becomes 0xFF80000000. Clamping happens after rounding.
- R8: `res_zero` is 1 exactly when the 40-bit value loaded into `res` is zero. It is updated together with `res`.
- R9: An operation presented with `in_valid` high at a rising edge appears on `res` and `res_zero` after that edge. `res_valid` is high for the cycle after each edge where `in_valid` was high, and low otherwise. Back-to-back operations are accepted on every clock.
- R10: When `in_valid` is low at an edge, `res` and `res_zero` keep their values.
- R11: While reset is asserted, `res`, `res_zero` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation request for this cycle |
| op_x | input | 16 | First operand |
| op_y | input | 16 | Second operand |
| x_signed | input | 1 | 1: op_x is two's-complement; 0: unsigned |
| y_signed | input | 1 | 1: op_y is two's-complement; 0: unsigned |
| frac_mode | input | 1 | Double the product |
| sub_mode | input | 1 | 0: add product; 1: subtract product |
| round_en | input | 1 | Round to nearest at bit 16 |
| sat_prod | input | 1 | Saturate the (-1)x(-1) fractional product |
| sat_acc | input | 1 | Clamp the result to signed 32-bit range |
| acc_in | input | 40 | Accumulator value to add to |
| res_valid | output | 1 | res holds a new result this cycle |
| res | output | 40 | Registered result |
| res_zero | output | 1 | res equals zero |

## Verification
The bench targets the 0x8000 x 0x8000 product in fractional mode, with and without product saturation and with unsigned operands. A design that tests the raw bits rather than the widened value would clamp an unsigned product that is positive and in range. It also drives sums that cross the 32-bit limits in both directions, together with a case where rounding alone pushes a value over the limit. That case catches a design that clamps before rounding, which would output 0x0080000000. Subtractions that cancel to exactly zero test the zero flag, and idle cycles between operations expose results or flags that drift when nothing is requested.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

  typedef struct packed {
    logic frac;
    logic sub;
    logic rnd;
    logic psat;
    logic asat;
  } mac_mode_t;

endpackage

// File: rtl/mac_opnd_ext.sv
module mac_opnd_ext #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         is_signed,
  output logic [W:0]   dout
);

  always_comb begin
    dout = {is_signed & din[W-1], din};
  end

endmodule

// File: rtl/mac_prod.sv
module mac_prod #(
  parameter int W     = 16,
  parameter int ACC_W = 40
) (
  input  logic [W:0]       xe,
  input  logic [W:0]       ye,
  input  logic             frac,
  input  logic             psat,
  output logic [ACC_W-1:0] prod
);

  localparam int PW = 2 * (W + 1);
  localparam logic [W:0] MOST_NEG = {2'b11, {(W-1){1'b0}}};
  localparam logic [ACC_W-1:0] PROD_MAX =
    {{(ACC_W-2*W+1){1'b0}}, {(2*W-1){1'b1}}};

  logic signed [PW-1:0] p_full;
  logic [ACC_W-1:0]     p_ext;
  logic [ACC_W-1:0]     p_scaled;
  logic                 corner;

  always_comb begin
    p_full   = $signed(xe) * $signed(ye);
    p_ext    = {{(ACC_W-PW){p_full[PW-1]}}, p_full};
    p_scaled = frac ? {p_ext[ACC_W-2:0], 1'b0} : p_ext;
    corner   = psat & frac & (xe == MOST_NEG) & (ye == MOST_NEG);
    prod     = corner ? PROD_MAX : p_scaled;
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int W     = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] prod,
  input  logic             sub,
  input  logic             rnd,
  input  logic             asat,
  output logic [ACC_W-1:0] result
);

  localparam int SAT_W = 2 * W;
  localparam int HI_W  = ACC_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (W - 1);
  localparam logic [ACC_W-1:0] POS_LIM  = {{HI_W{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM  = {{HI_W{1'b1}}, {(SAT_W-1){1'b0}}};

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] biased;
  logic [ACC_W-1:0] rounded;
  logic [HI_W-1:0]  top;
  logic             fits;

  always_comb begin
    sum     = sub ? (acc - prod) : (acc + prod);
    biased  = sum + HALF_LSB;
    rounded = rnd ? {biased[ACC_W-1:W], {W{1'b0}}} : sum;
    top     = rounded[ACC_W-1:SAT_W-1];
    fits    = (&top) | ~(|top);
    if (asat && !fits) begin
      result = rounded[ACC_W-1] ? NEG_LIM : POS_LIM;
    end else begin
      result = rounded;
    end
  end

endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit #(
  parameter int W     = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     op_x,
  input  logic [W-1:0]     op_y,
  input  logic             x_signed,
  input  logic             y_signed,
  input  logic             frac_mode,
  input  logic             sub_mode,
  input  logic             round_en,
  input  logic             sat_prod,
  input  logic             sat_acc,
  input  logic [ACC_W-1:0] acc_in,
  output logic             res_valid,
  output logic [ACC_W-1:0] res,
  output logic             res_zero
);
  import frac_mac_pkg::*;

  localparam int SAT_W = 2 * W;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  mac_mode_t mode;
  always_comb begin
    mode.frac = frac_mode;
    mode.sub  = sub_mode;
    mode.rnd  = round_en;
    mode.psat = sat_prod;
    mode.asat = sat_acc;
  end

  logic [W:0]       x_ext, y_ext;
  logic [ACC_W-1:0] prod_w, acc_res;

  mac_opnd_ext #(.W(W)) u_ext_x (.din(op_x), .is_signed(x_signed), .dout(x_ext));
  mac_opnd_ext #(.W(W)) u_ext_y (.din(op_y), .is_signed(y_signed), .dout(y_ext));

  mac_prod #(.W(W), .ACC_W(ACC_W)) u_prod (
    .xe(x_ext), .ye(y_ext), .frac(mode.frac), .psat(mode.psat), .prod(prod_w)
  );

  mac_accum #(.W(W), .ACC_W(ACC_W)) u_accum (
    .acc(acc_in), .prod(prod_w), .sub(mode.sub), .rnd(mode.rnd),
    .asat(mode.asat), .result(acc_res)
  );

  // next state
  logic [ACC_W-1:0] res_d;
  logic             zero_d, valid_d;
  always_comb begin
    valid_d = in_valid;
    res_d   = res;
    zero_d  = res_zero;
    if (in_valid) begin
      res_d  = acc_res;
      zero_d = (acc_res == '0);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      res       <= '0;
      res_zero  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res       <= res_d;
      res_zero  <= zero_d;
      res_valid <= valid_d;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    in_valid |=> res_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    !in_valid |=> !res_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    !in_valid |=> ($stable(res) && $stable(res_zero)));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    res_valid |-> (res_zero == (res == '0)));
  assert_round_clears_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && round_en && !sat_acc) |=> (res[W-1:0] == '0));
  assert_clamp_range_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && sat_acc) |=> ((&res[ACC_W-1:SAT_W-1]) || !(|res[ACC_W-1:SAT_W-1])));
  assert_frac_even_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    (frac_mode && !sat_prod) |-> (prod_w[0] == 1'b0));

endmodule

// File: tb/frac_mac_unit_tb.sv
`timescale 1ns/1ps
module frac_mac_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] op_x, op_y;
  logic        x_signed, y_signed, frac_mode, sub_mode, round_en, sat_prod, sat_acc;
  logic [39:0] acc_in;
  logic        res_valid, res_zero;
  logic [39:0] res;

  int n_chk = 0;
  int n_fail = 0;
  logic [39:0] last_res;
  logic        last_zero;

  always #10 clk = ~clk;

  frac_mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
    .x_signed(x_signed), .y_signed(y_signed), .frac_mode(frac_mode),
    .sub_mode(sub_mode), .round_en(round_en), .sat_prod(sat_prod),
    .sat_acc(sat_acc), .acc_in(acc_in), .res_valid(res_valid), .res(res),
    .res_zero(res_zero)
  );

  function automatic longint w40(input longint v);
    logic [39:0] t;
    t = v[39:0];
    return longint'($signed(t));
  endfunction

  function automatic logic [39:0] model(input logic [15:0] x, y,
      input logic xs, ys, fr, sb, rn, sp, sa, input logic [39:0] acc);
    longint xe, ye, p, a, r;
    xe = xs ? longint'($signed(x)) : longint'({48'd0, x});
    ye = ys ? longint'($signed(y)) : longint'({48'd0, y});
    p = xe * ye;
    if (fr) p = p * 2;
    if (sp && fr && xe == -64'sd32768 && ye == -64'sd32768) p = 64'sh7FFFFFFF;
    a = longint'($signed(acc));
    r = w40(sb ? a - p : a + p);
    if (rn) begin
      r = w40(r + 64'sd32768);
      r[15:0] = 16'h0;
    end
    if (sa) begin
      if (r > 64'sh7FFFFFFF) r = 64'sh7FFFFFFF;
      else if (r < -64'sh80000000) r = -64'sh80000000;
    end
    return r[39:0];
  endfunction

  task automatic check(input string tag, input logic [39:0] er, input logic ez, input logic ev);
    n_chk++;
    if (res !== er || res_zero !== ez || res_valid !== ev) begin
      n_fail++;
      $display("FAIL %s: res=%h zero=%b valid=%b expected res=%h zero=%b valid=%b",
               tag, res, res_zero, res_valid, er, ez, ev);
    end
  endtask

  // called at a falling edge; result sampled at the next falling edge
  task automatic apply(input string tag, input logic vld, input logic [15:0] x, y,
      input logic xs, ys, fr, sb, rn, sp, sa, input logic [39:0] acc);
    in_valid = vld; op_x = x; op_y = y; x_signed = xs; y_signed = ys;
    frac_mode = fr; sub_mode = sb; round_en = rn; sat_prod = sp; sat_acc = sa;
    acc_in = acc;
    @(negedge clk);
    if (vld) begin
      last_res  = model(x, y, xs, ys, fr, sb, rn, sp, sa, acc);
      last_zero = (last_res == 40'h0);
      check(tag, last_res, last_zero, 1'b1);
    end else begin
      check(tag, last_res, last_zero, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_x = '0; op_y = '0; x_signed = 1'b0;
    y_signed = 1'b0; frac_mode = 1'b0; sub_mode = 1'b0; round_en = 1'b0;
    sat_prod = 1'b0; sat_acc = 1'b0; acc_in = '0;
    last_res = '0; last_zero = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset", 40'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 after release", 40'h0, 1'b0, 1'b0);

    // R2 signed integer product
    apply("R2 signed", 1, 16'hFFFD, 16'h0007, 1, 1, 0, 0, 0, 0, 0, 40'd100);
    check("R2 literal", 40'd79, 1'b0, 1'b1);
    // R1 extension control
    apply("R1 x unsigned", 1, 16'hFFFF, 16'h0002, 0, 1, 0, 0, 0, 0, 0, 40'd0);
    check("R1 literal", 40'd131070, 1'b0, 1'b1);
    apply("R1 both unsigned", 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 40'd0);
    apply("R1 y unsigned", 1, 16'h8001, 16'hC000, 1, 0, 0, 0, 0, 0, 0, 40'd5);
    // R3 fractional
    apply("R3 frac", 1, 16'h4000, 16'h4000, 1, 1, 1, 0, 0, 0, 0, 40'd0);
    check("R3 literal", 40'h0020000000, 1'b0, 1'b1);
    // R4 product saturation
    apply("R4 corner", 1, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 1, 0, 40'd0);
    check("R4 literal sat", 40'h007FFFFFFF, 1'b0, 1'b1);
    apply("R4 no psat", 1, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 0, 0, 40'd0);
    check("R4 literal raw", 40'h0080000000, 1'b0, 1'b1);
    apply("R4 unsigned", 1, 16'h8000, 16'h8000, 0, 0, 1, 0, 0, 1, 0, 40'd0);
    apply("R4 integer", 1, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, 1, 0, 40'd0);
    // R5 subtract
    apply("R5 sub", 1, 16'd10, 16'd10, 1, 1, 0, 1, 0, 0, 0, 40'd1000);
    check("R5 literal", 40'd900, 1'b0, 1'b1);
    apply("R5 wrap", 1, 16'd1, 16'd1, 1, 1, 0, 1, 0, 0, 0, 40'h8000000000);
    // R6 rounding
    apply("R6 up", 1, 16'd0, 16'd0, 1, 1, 0, 0, 1, 0, 0, 40'h0000018000);
    check("R6 literal up", 40'h0000020000, 1'b0, 1'b1);
    apply("R6 down", 1, 16'd0, 16'd0, 1, 1, 0, 0, 1, 0, 0, 40'h0000017FFF);
    check("R6 literal down", 40'h0000010000, 1'b0, 1'b1);
    // R7 clamping
    apply("R7 pos", 1, 16'h0100, 16'h0100, 1, 1, 0, 0, 0, 0, 1, 40'h007FFFFFF0);
    check("R7 literal pos", 40'h007FFFFFFF, 1'b0, 1'b1);
    apply("R7 neg", 1, 16'd1, 16'd1, 1, 1, 0, 1, 0, 0, 1, 40'hFF80000000);
    check("R7 literal neg", 40'hFF80000000, 1'b0, 1'b1);
    apply("R7 after round", 1, 16'd0, 16'd0, 1, 1, 0, 0, 1, 0, 1, 40'h007FFF8000);
    check("R7 literal order", 40'h007FFFFFFF, 1'b0, 1'b1);
    // R8 zero flag
    apply("R8 zero", 1, 16'd3, 16'd4, 1, 1, 0, 1, 0, 0, 0, 40'd12);
    check("R8 literal", 40'h0, 1'b1, 1'b1);
    // R10 idle holds result and flag, R9 valid drops
    apply("R10 hold", 0, 16'hFFFF, 16'hFFFF, 1, 1, 1, 1, 1, 1, 1, 40'h1234567890);
    apply("R10 hold2", 0, 16'h1234, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 40'h0);
    apply("R9 resume", 1, 16'd2, 16'd3, 1, 1, 0, 0, 0, 0, 0, 40'd1);

    // random vectors, back-to-back with occasional idle cycles
    for (int i = 0; i < 4000; i++) begin
      logic [39:0] acc;
      logic [15:0] rx, ry;
      logic [7:0]  m;
      m  = 8'($urandom);
      rx = 16'($urandom);
      ry = 16'($urandom);
      if (m[7:6] == 2'b00) rx = 16'h8000;
      if (m[7:6] == 2'b00) ry = 16'h8000;
      acc = {8'($urandom), 32'($urandom)};
      if (m[5]) acc = 40'($signed(acc[33:0]));
      apply("R5 random", (($urandom % 8) != 0), rx, ry, m[0], m[1], m[2], m[3],
            m[4], m[6], m[7], acc);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule